// File: doc/BRIEF.md
# Sequence-Unlocked Watchdog Timer

This block is a watchdog timer for a small 8-bit controller. It monitors a byte-wide special-function write bus. Software arms the watchdog, or pushes its deadline back, with a two-byte key written to a dedicated kick register. Any other traffic on that register has no effect on the count. A control register holds a 3-bit exponent for a power-of-two prescaler, a mode bit that permits key detection, and the enable bit.

While enabled, the block counts machine-cycle strobes through the prescaler into a 14-bit counter. When the counter wraps, the block drives a reset pulse for one clock and disables itself. A rate input makes two machine-cycle strobes count as one step. This matches a core that runs in clock-doubled mode, where each cycle lasts half as long.

Top module: `seq_watchdog`

## Requirements
- R1: A synchronous reset clears the control register, including enable and the prescaler field, to 0x00. It also forgets the last byte written to the kick register, so a key half written before reset cannot be completed after it. `wdtReset` is low after reset.
- R2: A write to address 0xA7 stores the whole byte, and `ctrlValue` shows it on the next cycle. Bits [7:5] are the prescaler exponent N, bit 2 is the key-detection mode, and bit 0 is the enable. Writing 0 to bit 0 stops the watchdog.
- R3: When the mode bit is 1, the sequence of writing 0x1E to address 0xA6 and then 0xE1 as the next write to 0xA6 sets the enable bit and clears the prescaler and the counter.
- R4: Only consecutive writes to 0xA6 form the key. Writes to other addresses in between do not break it. Any other byte written to 0xA6 in between does break it. A lone 0xE1 neither arms nor restarts the watchdog.
- R5: When the mode bit is 0, the key sequence has no effect on the enable bit.
- R6: While enabled, each qualified machine cycle advances the prescaler. The counter steps once every 2^N qualified cycles. After 2^14 × 2^N qualified cycles from a restart, `wdtReset` is high for exactly one clock.
- R7: The expiry that raises `wdtReset` also clears the enable bit, in the same clock edge.
- R8: With `halfRate` high, two `cycleTick` strobes make one qualified cycle, so expiry takes twice as many strobes.
- R9: A valid key received while the count is running restarts the full interval from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sfrWe | input | 1 | Register write strobe |
| sfrAddr | input | 8 | Register write address |
| sfrWdata | input | 8 | Register write data |
| cycleTick | input | 1 | One pulse per machine cycle |
| halfRate | input | 1 | Clock-doubled mode: two strobes count as one cycle |
| ctrlValue | output | 8 | Current control register contents |
| wdtReset | output | 1 | One-clock watchdog reset pulse |

## Verification
The assertions assume that the write bus carries at most one write per clock and that `rst` is held for at least one edge before any write. They also assume that `cycleTick` and `halfRate` are ordinary synchronous levels. The stimulus drives every input at the falling edge and issues each write as a single-cycle strobe. It keeps `cycleTick` low while the table of register writes runs, so the only changes to the enable bit come from writes and keys. It changes `halfRate` only while the watchdog is disabled, so no half-counted strobe is left over from a previous rate.

// File: rtl/wdt_seq_pkg.sv
package wdt_seq_pkg;
  localparam int SCALE_W = 3;

  typedef struct packed {
    logic               restart;
    logic               enable;
    logic [SCALE_W-1:0] scale;
  } wdtStrobe_t;
endpackage

// File: rtl/wdt_seq_ctrl.sv
module wdt_seq_ctrl
  import wdt_seq_pkg::*;
#(
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 8,
  parameter logic [7:0]  KICK_ADDR  = 8'hA6,
  parameter logic [7:0]  CTRL_ADDR  = 8'hA7,
  parameter logic [7:0]  KEY_FIRST  = 8'h1E,
  parameter logic [7:0]  KEY_SECOND = 8'hE1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sfrWe,
  input  logic [ADDR_W-1:0] sfrAddr,
  input  logic [DATA_W-1:0] sfrWdata,
  input  logic              expireNow,
  output wdtStrobe_t        strobe,
  output logic [DATA_W-1:0] ctrlReg
);
  localparam int EN_BIT    = 0;
  localparam int HW_BIT    = 2;
  localparam int SCALE_LSB = DATA_W - SCALE_W;

  logic [DATA_W-1:0] prevByte;
  logic kickWr, ctrlWr, armHit;

  assign kickWr = sfrWe && (sfrAddr == ADDR_W'(KICK_ADDR));
  assign ctrlWr = sfrWe && (sfrAddr == ADDR_W'(CTRL_ADDR));
  // Key completes only on the second byte with the first one remembered.
  assign armHit = kickWr && ctrlReg[HW_BIT] &&
                  (sfrWdata == DATA_W'(KEY_SECOND)) &&
                  (prevByte == DATA_W'(KEY_FIRST));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrlReg  <= '0;
      prevByte <= '0;
    end else begin
      if (ctrlWr) ctrlReg <= sfrWdata;
      if (kickWr) prevByte <= sfrWdata;
      if (armHit)         ctrlReg[EN_BIT] <= 1'b1;
      else if (expireNow) ctrlReg[EN_BIT] <= 1'b0;
    end
  end

  always_comb begin
    strobe.restart = armHit;
    strobe.enable  = ctrlReg[EN_BIT];
    strobe.scale   = ctrlReg[SCALE_LSB +: SCALE_W];
  end

  // R1: reset leaves a clean register file
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (ctrlReg == '0 && prevByte == '0));

  // R3: a completed key in hardware mode enables the watchdog
  p_arm_enables_r3: assert property (@(posedge clk) disable iff (rst)
    (sfrWe && sfrAddr == ADDR_W'(KICK_ADDR) && sfrWdata == DATA_W'(KEY_SECOND)
     && prevByte == DATA_W'(KEY_FIRST) && ctrlReg[HW_BIT]) |=> ctrlReg[EN_BIT]);

  // R5: without the mode bit, kick writes never enable
  p_mode_gate_r5: assert property (@(posedge clk) disable iff (rst)
    (!ctrlReg[HW_BIT] && !ctrlReg[EN_BIT] && !(sfrWe && sfrAddr == ADDR_W'(CTRL_ADDR)))
      |=> !ctrlReg[EN_BIT]);

  // R7: expiry disables the watchdog
  p_expire_disable_r7: assert property (@(posedge clk) disable iff (rst)
    expireNow |=> !ctrlReg[EN_BIT]);
endmodule

// File: rtl/wdt_seq_datapath.sv
module wdt_seq_datapath
  import wdt_seq_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       cycleTick,
  input  logic       halfRate,
  input  wdtStrobe_t strobe,
  output logic       expireNow,
  output logic       wdtReset
);
  localparam int PRE_W = (1 << SCALE_W) - 1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [PRE_W-1:0] PRE_ONE = PRE_W'(1);

  logic [PRE_W-1:0] preCnt, preLimit;
  logic [CNT_W-1:0] count;
  logic halfPhase, step, preDone, atMax;

  // Terminal prescaler value is 2^N - 1.
  assign preLimit  = ~({PRE_W{1'b1}} << strobe.scale);
  assign step      = strobe.enable && cycleTick && (!halfRate || halfPhase);
  assign preDone   = (preCnt == preLimit);
  assign atMax     = &count;
  assign expireNow = step && preDone && atMax && !strobe.restart;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt    <= '0;
      count     <= '0;
      halfPhase <= 1'b0;
      wdtReset  <= 1'b0;
    end else if (strobe.restart) begin
      preCnt    <= '0;
      count     <= '0;
      halfPhase <= 1'b0;
      wdtReset  <= 1'b0;
    end else begin
      wdtReset <= expireNow;
      if (strobe.enable && cycleTick && halfRate) halfPhase <= ~halfPhase;
      if (step) begin
        if (preDone) begin
          preCnt <= '0;
          count  <= count + CNT_ONE;
        end else begin
          preCnt <= preCnt + PRE_ONE;
        end
      end
    end
  end

  // R6: the reset pulse lasts one clock
  p_pulse_single_r6: assert property (@(posedge clk) disable iff (rst)
    wdtReset |=> !wdtReset);

  // R6: a pulse only follows an enabled cycle
  p_pulse_enabled_r6: assert property (@(posedge clk) disable iff (rst)
    wdtReset |-> $past(strobe.enable));

  // R9: a restart zeroes the whole count chain
  p_restart_zero_r9: assert property (@(posedge clk) disable iff (rst)
    strobe.restart |=> (count == '0 && preCnt == '0 && !wdtReset));
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog
  import wdt_seq_pkg::*;
#(
  parameter int         CNT_W     = 14,
  parameter logic [7:0] KICK_ADDR = 8'hA6,
  parameter logic [7:0] CTRL_ADDR = 8'hA7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sfrWe,
  input  logic [7:0] sfrAddr,
  input  logic [7:0] sfrWdata,
  input  logic       cycleTick,
  input  logic       halfRate,
  output logic [7:0] ctrlValue,
  output logic       wdtReset
);
  wdtStrobe_t strobe;
  logic       expireNow;

  wdt_seq_ctrl #(
    .ADDR_W(8), .DATA_W(8),
    .KICK_ADDR(KICK_ADDR), .CTRL_ADDR(CTRL_ADDR),
    .KEY_FIRST(8'h1E), .KEY_SECOND(8'hE1)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .expireNow(expireNow),
    .strobe(strobe), .ctrlReg(ctrlValue)
  );

  wdt_seq_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst(rst), .cycleTick(cycleTick), .halfRate(halfRate),
    .strobe(strobe), .expireNow(expireNow), .wdtReset(wdtReset)
  );
endmodule

// File: tb/seq_watchdog_tb.sv
`timescale 1ns/1ps
module seq_watchdog_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sfrWe = 1'b0;
  logic [7:0] sfrAddr = '0;
  logic [7:0] sfrWdata = '0;
  logic cycleTick = 1'b0;
  logic halfRate = 1'b0;
  logic [7:0] ctrlValue;
  logic wdtReset;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  seq_watchdog u_dut (
    .clk(clk), .rst(rst), .sfrWe(sfrWe), .sfrAddr(sfrAddr),
    .sfrWdata(sfrWdata), .cycleTick(cycleTick), .halfRate(halfRate),
    .ctrlValue(ctrlValue), .wdtReset(wdtReset)
  );

  // {reqId, addr, data, expected ctrlValue}
  localparam int NVEC = 16;
  localparam logic [27:0] VEC [NVEC] = '{
    {4'd2, 8'hA7, 8'h04, 8'h04},  // R2 mode on
    {4'd3, 8'hA6, 8'h1E, 8'h04},  // R3 first key byte
    {4'd3, 8'hA6, 8'hE1, 8'h05},  // R3 armed
    {4'd2, 8'hA7, 8'h04, 8'h04},  // R2 write clears enable
    {4'd4, 8'hA6, 8'hE1, 8'h04},  // R4 lone second byte
    {4'd4, 8'hA6, 8'h1E, 8'h04},  // R4
    {4'd4, 8'hA6, 8'h55, 8'h04},  // R4 intruding byte
    {4'd4, 8'hA6, 8'hE1, 8'h04},  // R4 broken key
    {4'd4, 8'hA6, 8'h1E, 8'h04},  // R4
    {4'd4, 8'hA5, 8'h77, 8'h04},  // R4 other address in between
    {4'd4, 8'hA6, 8'hE1, 8'h05},  // R4 key still valid
    {4'd5, 8'hA7, 8'h00, 8'h00},  // R5 mode off
    {4'd5, 8'hA6, 8'h1E, 8'h00},  // R5
    {4'd5, 8'hA6, 8'hE1, 8'h00},  // R5 key ignored
    {4'd2, 8'hA7, 8'hE4, 8'hE4},  // R2 full byte held
    {4'd2, 8'hA7, 8'h04, 8'h04}   // R2
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sfrWrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrWe = 1'b1; sfrAddr = a; sfrWdata = d;
    @(negedge clk);
    sfrWe = 1'b0;
  endtask

  task automatic kick();
    sfrWrite(8'hA6, 8'h1E);
    sfrWrite(8'hA6, 8'hE1);
  endtask

  // Runs ticks from a fresh restart and measures the edges until the pulse.
  task automatic runExpire(input int expEdges, input string req);
    int n = 0;
    bit seen = 1'b0;
    cycleTick = 1'b1;
    while (!seen && n < expEdges + 16) begin
      @(posedge clk); n++; #2;
      if (wdtReset) seen = 1'b1;
    end
    check(seen && n == expEdges, req, n, expEdges);
    check(ctrlValue[0] == 1'b0, "R7 enable cleared", ctrlValue[0], 0);
    @(posedge clk); #2;
    check(wdtReset == 1'b0, "R6 single pulse", wdtReset, 0);
    cycleTick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog timeout actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(ctrlValue == 8'h00, "R1 ctrl after reset", ctrlValue, 0);
    check(wdtReset == 1'b0, "R1 no pulse after reset", wdtReset, 0);

    for (int i = 0; i < NVEC; i++) begin
      sfrWrite(VEC[i][23:16], VEC[i][15:8]);
      total++;
      if (ctrlValue != VEC[i][7:0]) begin
        bad++;
        $display("FAIL R%0d row %0d actual=%0h expected=%0h",
                 VEC[i][27:24], i, ctrlValue, VEC[i][7:0]);
      end
    end

    // R6 scale 0: 2^14 steps
    sfrWrite(8'hA7, 8'h04);
    kick();
    runExpire(16384, "R6 expiry scale0");

    // R6 scale 1: 2^15 steps
    sfrWrite(8'hA7, 8'h24);
    kick();
    check(ctrlValue == 8'h25, "R3 armed with scale", ctrlValue, 8'h25);
    runExpire(32768, "R6 expiry scale1");

    // R8 half rate
    sfrWrite(8'hA7, 8'h04);
    halfRate = 1'b1;
    kick();
    runExpire(32768, "R8 half-rate expiry");
    halfRate = 1'b0;

    // R9 restart mid-count
    kick();
    begin
      bit early = 1'b0;
      cycleTick = 1'b1;
      for (int k = 0; k < 10000; k++) begin
        @(posedge clk); #2;
        if (wdtReset) early = 1'b1;
      end
      cycleTick = 1'b0;
      check(!early, "R9 no pulse before restart", early, 0);
    end
    kick();
    runExpire(16384, "R9 full interval after restart");

    // R1 reset forgets the first key byte
    sfrWrite(8'hA6, 8'h1E);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(ctrlValue == 8'h00, "R1 ctrl cleared", ctrlValue, 0);
    sfrWrite(8'hA7, 8'h04);
    sfrWrite(8'hA6, 8'hE1);
    check(ctrlValue == 8'h04, "R1 half key forgotten", ctrlValue, 8'h04);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule